// File: doc/BRIEF.md
# Reset-Time Boot Vector Selector

This block decides, when the core's reset is released, where an 8-bit microcontroller begins fetching code. The reset input and two strap pins pass through a shared two-flop synchronizer. The strap pins are the external-fetch strap and the strobe strap; the strobe strap is the pin that becomes an output after reset. The block finds the falling edge of the synchronized reset and takes the strap values of that same sample. It combines them with a stored jump-enable bit and a stored software vector byte. The result is a 16-bit start address and a 2-bit mode code, and both are announced by a one-cycle valid pulse.

The jump bit and the vector byte live in a small store. A power-on input loads it with defaults, and a write port with an enable, a one-bit select and a data byte updates it. A write changes only the store. The selection that is already in force stays as it is until the next reset release. The block also produces the drive enable for the strobe pin. That enable is released only after the reset release has been sampled and the choice is made.

Top module: `boot_vector_select`

## Requirements
- R1: The straps count only at the synchronized reset release. Values they held earlier in reset, and any change made after the release, leave the selection unchanged.
- R2: If the external-fetch strap is 1 and the strobe strap is 0 at release, the mode becomes 01 and the address becomes ROM_ADDR (0xF800 by default), whatever the jump bit and the vector byte hold.
- R3: Without that strap pattern, a jump bit of 1 gives mode 00 (application) and address 0x0000.
- R4: Without the strap pattern, a jump bit of 0 with a vector byte of 0xFC gives mode 01 and address ROM_ADDR.
- R5: Without the strap pattern, a jump bit of 0 with a vector byte other than 0xFC gives mode 10 (customer loader) and an address whose high byte is the vector byte and whose low byte is 0x00.
- R6: While power-on is high, the outputs are mode 00, address 0, valid 0 and strobe enable 0. Power-on also loads the jump bit with 1 and the vector byte with 0xFC.
- R7: A write with select 0 stores data bit 0 as the jump bit. A write with select 1 stores the data byte as the vector byte. Mode and address do not move until the next release.
- R8: Suppose the reset pin falls before clock edge k. Then start_valid is high for exactly the one cycle that follows edge k+2.
- R9: The strobe enable goes low two edges after the reset pin rises, and it stays low through reset. It turns on in the same cycle as start_valid and stays on until reset returns.
- R10: Mode and address hold their values between releases, including the whole time reset is high, and the mode code is never 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Synchronous power-on initialisation, active high |
| rst_pin | input | 1 | Core reset pin, active high, asynchronous to clk |
| strap_ext_i | input | 1 | External-fetch strap pin |
| strap_strobe_i | input | 1 | Strobe strap pin, read as input while in reset |
| strobe_oe_o | output | 1 | Drive enable for the strobe pin after reset |
| cfg_we | input | 1 | Store write enable |
| cfg_sel | input | 1 | Store select: 0 jump bit, 1 vector byte |
| cfg_wdata | input | 8 | Store write data |
| start_addr | output | 16 | Selected first fetch address |
| boot_mode | output | 2 | 00 application, 01 on-chip loader, 10 customer loader |
| start_valid | output | 1 | One-cycle pulse when a new selection is made |

## Verification
Several rules are checked by assertions on every cycle. These are the one-cycle width of the valid pulse and its fixed delay after the detected release. They also cover mode and address holding still when no release is seen, the strap override, the form of a customer-loader address, the strobe enable being off during reset, and store writes landing. Other behaviour shows only in the bench's scenarios. That covers the exact sampling instant of the straps against changes before and after release, and the power-on defaults. It also covers the full map from strap, jump and vector values to mode and address, which a sweep over every vector byte exercises, and the rule that a store write waits for the next release.

// File: rtl/bvs_pkg.sv
package bvs_pkg;

    localparam int START_W = 16;
    localparam int VEC_W   = 8;
    localparam int PAD_W   = START_W - VEC_W;

    localparam logic SEL_JUMP = 1'b0;
    localparam logic SEL_VEC  = 1'b1;

    typedef enum logic [1:0] {
        MODE_APP     = 2'b00,
        MODE_ROMLDR  = 2'b01,
        MODE_USERLDR = 2'b10
    } boot_mode_e;

    typedef struct packed {
        boot_mode_e             mode;
        logic [START_W-1:0]     addr;
    } boot_choice_t;

    typedef struct packed {
        logic ext;
        logic strobe;
    } strap_t;

    function automatic boot_choice_t pick_boot(
        input strap_t             s,
        input logic               jump,
        input logic [VEC_W-1:0]   vec,
        input logic [START_W-1:0] rom_addr,
        input logic [VEC_W-1:0]   empty_vec
    );
        boot_choice_t r;
        if (s.ext && !s.strobe) begin
            r.mode = MODE_ROMLDR;
            r.addr = rom_addr;
        end else if (jump) begin
            r.mode = MODE_APP;
            r.addr = '0;
        end else if (vec == empty_vec) begin
            r.mode = MODE_ROMLDR;
            r.addr = rom_addr;
        end else begin
            r.mode = MODE_USERLDR;
            r.addr = {vec, {PAD_W{1'b0}}};
        end
        return r;
    endfunction

endpackage

// File: rtl/bvs_sync.sv
module bvs_sync #(
    parameter int              WIDTH  = 1,
    parameter int              STAGES = 2,
    parameter logic [WIDTH-1:0] INIT  = '0
) (
    input  logic             clk,
    input  logic             por,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [WIDTH-1:0] r;
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (por) r <= INIT;
                else     r <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (por) r <= INIT;
                else     r <= g_stage[i-1].r;
            end
        end
    end

    assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/bvs_store.sv
module bvs_store
    import bvs_pkg::*;
#(
    parameter logic             JUMP_INIT = 1'b1,
    parameter logic [VEC_W-1:0] VEC_INIT  = 8'hFC
) (
    input  logic             clk,
    input  logic             por,
    input  logic             we,
    input  logic             sel,
    input  logic [VEC_W-1:0] wdata,
    output logic             jump,
    output logic [VEC_W-1:0] vec
);

    always_ff @(posedge clk) begin
        if (por) begin
            jump <= JUMP_INIT;
            vec  <= VEC_INIT;
        end else if (we) begin
            if (sel == SEL_JUMP) jump <= wdata[0];
            else                 vec  <= wdata;
        end
    end

    // R7
    vec_write_chk: assert property (@(posedge clk) disable iff (por)
        (we && sel == SEL_VEC) |=> (vec == $past(wdata)));

    // R7
    jump_write_chk: assert property (@(posedge clk) disable iff (por)
        (we && sel == SEL_JUMP) |=> (jump == $past(wdata[0])));

    // R7
    store_idle_chk: assert property (@(posedge clk) disable iff (por)
        !we |=> ($stable(vec) && $stable(jump)));

endmodule

// File: rtl/bvs_decide.sv
module bvs_decide
    import bvs_pkg::*;
#(
    parameter logic [START_W-1:0] ROM_ADDR  = 16'hF800,
    parameter logic [VEC_W-1:0]   EMPTY_VEC = 8'hFC
) (
    input  logic             clk,
    input  logic             por,
    input  logic             rst_s,
    input  strap_t           strap,
    input  logic             jump,
    input  logic [VEC_W-1:0] vec,
    output boot_choice_t     choice_q,
    output logic             start_valid,
    output logic             strobe_oe
);

    logic         rst_prev;
    logic         fall;
    boot_choice_t choice_d;

    always_ff @(posedge clk) begin
        if (por) rst_prev <= 1'b1;
        else     rst_prev <= rst_s;
    end

    assign fall = rst_prev & ~rst_s;

    always_comb choice_d = pick_boot(strap, jump, vec, ROM_ADDR, EMPTY_VEC);

    always_ff @(posedge clk) begin
        if (por) begin
            choice_q    <= '{mode: MODE_APP, addr: '0};
            start_valid <= 1'b0;
            strobe_oe   <= 1'b0;
        end else begin
            start_valid <= fall;
            if (fall) choice_q <= choice_d;
            if (rst_s)     strobe_oe <= 1'b0;
            else if (fall) strobe_oe <= 1'b1;
        end
    end

    // R8
    valid_after_fall_chk: assert property (@(posedge clk) disable iff (por)
        fall |=> start_valid);

    // R8
    valid_single_chk: assert property (@(posedge clk) disable iff (por)
        start_valid |=> !start_valid);

    // R2
    strap_force_chk: assert property (@(posedge clk) disable iff (por)
        (fall && strap.ext && !strap.strobe) |=>
            (choice_q.mode == MODE_ROMLDR && choice_q.addr == ROM_ADDR));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (por)
        !fall |=> ($stable(choice_q.mode) && $stable(choice_q.addr)));

    // R9
    oe_off_chk: assert property (@(posedge clk) disable iff (por)
        rst_s |=> !strobe_oe);

    // R9
    oe_on_chk: assert property (@(posedge clk) disable iff (por)
        start_valid |-> strobe_oe);

    // R5
    user_addr_chk: assert property (@(posedge clk) disable iff (por)
        (choice_q.mode == MODE_USERLDR) |->
            (choice_q.addr[PAD_W-1:0] == '0 && choice_q.addr[START_W-1:PAD_W] != EMPTY_VEC));

    // R3
    app_addr_chk: assert property (@(posedge clk) disable iff (por)
        (choice_q.mode == MODE_APP) |-> (choice_q.addr == '0));

endmodule

// File: rtl/boot_vector_select.sv
module boot_vector_select
    import bvs_pkg::*;
#(
    parameter logic [START_W-1:0] ROM_ADDR    = 16'hF800,
    parameter logic [VEC_W-1:0]   EMPTY_VEC   = 8'hFC,
    parameter logic               JUMP_INIT   = 1'b1,
    parameter int                 SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               por,
    input  logic               rst_pin,
    input  logic               strap_ext_i,
    input  logic               strap_strobe_i,
    output logic               strobe_oe_o,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [VEC_W-1:0]   cfg_wdata,
    output logic [START_W-1:0] start_addr,
    output logic [1:0]         boot_mode,
    output logic               start_valid
);

    localparam int SYNC_W = 3;
    localparam logic [SYNC_W-1:0] SYNC_INIT = 3'b101;

    logic [SYNC_W-1:0] pins_raw;
    logic [SYNC_W-1:0] pins_s;
    strap_t            strap_s;
    logic              rst_s;
    logic              jump;
    logic [VEC_W-1:0]  vec;
    boot_choice_t      choice_q;

    assign pins_raw = {rst_pin, strap_ext_i, strap_strobe_i};

    bvs_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES),
        .INIT   (SYNC_INIT)
    ) u_sync (
        .clk (clk),
        .por (por),
        .d   (pins_raw),
        .q   (pins_s)
    );

    assign rst_s          = pins_s[2];
    assign strap_s.ext    = pins_s[1];
    assign strap_s.strobe = pins_s[0];

    bvs_store #(
        .JUMP_INIT (JUMP_INIT),
        .VEC_INIT  (EMPTY_VEC)
    ) u_store (
        .clk   (clk),
        .por   (por),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .jump  (jump),
        .vec   (vec)
    );

    bvs_decide #(
        .ROM_ADDR  (ROM_ADDR),
        .EMPTY_VEC (EMPTY_VEC)
    ) u_decide (
        .clk         (clk),
        .por         (por),
        .rst_s       (rst_s),
        .strap       (strap_s),
        .jump        (jump),
        .vec         (vec),
        .choice_q    (choice_q),
        .start_valid (start_valid),
        .strobe_oe   (strobe_oe_o)
    );

    assign start_addr = choice_q.addr;
    assign boot_mode  = choice_q.mode;

    // R10
    mode_legal_chk: assert property (@(posedge clk) disable iff (por)
        boot_mode != 2'b11);

endmodule

// File: tb/boot_vector_select_test.sv
module boot_vector_select_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] ROM = 16'hF800;

    logic        clk = 1'b0;
    logic        por;
    logic        rst_pin;
    logic        strap_ext_i;
    logic        strap_strobe_i;
    logic        strobe_oe_o;
    logic        cfg_we;
    logic        cfg_sel;
    logic [7:0]  cfg_wdata;
    logic [15:0] start_addr;
    logic [1:0]  boot_mode;
    logic        start_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [1:0]  last_mode;
    logic [15:0] last_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_vector_select uut (
        .clk            (clk),
        .por            (por),
        .rst_pin        (rst_pin),
        .strap_ext_i    (strap_ext_i),
        .strap_strobe_i (strap_strobe_i),
        .strobe_oe_o    (strobe_oe_o),
        .cfg_we         (cfg_we),
        .cfg_sel        (cfg_sel),
        .cfg_wdata      (cfg_wdata),
        .start_addr     (start_addr),
        .boot_mode      (boot_mode),
        .start_valid    (start_valid)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic write_cfg(input logic sel, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic boot_cycle(input logic ea, input logic st,
                              input logic [1:0] emode, input logic [15:0] eaddr,
                              input string req);
        @(negedge clk);
        rst_pin = 1'b1;
        strap_ext_i = ea; strap_strobe_i = st;
        repeat (3) @(negedge clk);
        chk(strobe_oe_o == 1'b0, "R9", "oe during reset", strobe_oe_o, 0);
        chk(start_valid == 1'b0, "R8", "valid during reset", start_valid, 0);
        chk(boot_mode == last_mode && start_addr == last_addr, "R10", "hold in reset",
            {boot_mode, start_addr}, {last_mode, last_addr});
        // R1: opposite strap values while reset is still high
        strap_ext_i = ~ea; strap_strobe_i = ~st;
        @(negedge clk);
        strap_ext_i = ea; strap_strobe_i = st;
        rst_pin = 1'b0;
        @(negedge clk);
        // R1: flip straps after the sampled edge
        strap_ext_i = ~ea; strap_strobe_i = ~st;
        chk(start_valid == 1'b0, "R8", "valid early 1", start_valid, 0);
        @(negedge clk);
        chk(start_valid == 1'b0, "R8", "valid early 2", start_valid, 0);
        @(negedge clk);
        chk(start_valid == 1'b1, "R8", "valid pulse", start_valid, 1);
        chk(boot_mode == emode, req, "mode", boot_mode, emode);
        chk(start_addr == eaddr, req, "addr", start_addr, eaddr);
        chk(strobe_oe_o == 1'b1, "R9", "oe after release", strobe_oe_o, 1);
        @(negedge clk);
        chk(start_valid == 1'b0, "R8", "valid width", start_valid, 0);
        chk(boot_mode == emode && start_addr == eaddr, "R10", "hold after pulse",
            {boot_mode, start_addr}, {emode, eaddr});
        chk(strobe_oe_o == 1'b1, "R9", "oe stays on", strobe_oe_o, 1);
        last_mode = emode;
        last_addr = eaddr;
    endtask

    initial begin
        por = 1'b1; rst_pin = 1'b1;
        strap_ext_i = 1'b0; strap_strobe_i = 1'b1;
        cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = 8'h00;
        last_mode = 2'b00; last_addr = 16'h0000;
        repeat (4) @(negedge clk);
        chk(boot_mode == 2'b00, "R6", "por mode", boot_mode, 0);
        chk(start_addr == 16'h0000, "R6", "por addr", start_addr, 0);
        chk(start_valid == 1'b0, "R6", "por valid", start_valid, 0);
        chk(strobe_oe_o == 1'b0, "R6", "por oe", strobe_oe_o, 0);
        por = 1'b0;

        // R6: defaults jump=1 -> application
        boot_cycle(1'b0, 1'b1, 2'b00, 16'h0000, "R6");
        // R6: default vector 0xFC with jump cleared -> on-chip loader
        write_cfg(1'b0, 8'h00);
        boot_cycle(1'b0, 1'b1, 2'b01, ROM, "R6");

        // R7: writes while running leave the selection alone
        write_cfg(1'b1, 8'h12);
        repeat (4) begin
            @(negedge clk);
            chk(boot_mode == 2'b01 && start_addr == ROM && start_valid == 1'b0, "R7",
                "no effect before reset", {boot_mode, start_addr}, {2'b01, ROM});
        end
        boot_cycle(1'b0, 1'b0, 2'b10, 16'h1200, "R7");

        // Full sweep over straps, jump bit and every vector byte
        for (int e = 0; e < 2; e++) begin
            for (int s = 0; s < 2; s++) begin
                for (int j = 0; j < 2; j++) begin
                    for (int v = 0; v < 256; v++) begin
                        logic [1:0]  m;
                        logic [15:0] a;
                        string       tag;
                        if (e == 1 && s == 0) begin
                            m = 2'b01; a = ROM; tag = "R1 R2";
                        end else if (j == 1) begin
                            m = 2'b00; a = 16'h0000; tag = "R1 R3";
                        end else if (v == 8'hFC) begin
                            m = 2'b01; a = ROM; tag = "R1 R4";
                        end else begin
                            m = 2'b10; a = v[7:0] * 16'd256; tag = "R1 R5";
                        end
                        write_cfg(1'b0, 8'(j));
                        write_cfg(1'b1, 8'(v));
                        boot_cycle(e[0], s[0], m, a, tag);
                    end
                end
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule